// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of data words from one clock domain to another when the two clocks have no fixed phase or frequency relationship. A producer pushes words on the write clock. A consumer pops them on the read clock in the same order. The storage is a 256-entry register array held inside the block. It is written on the write clock and read on the read clock.

Each side keeps its own pointer in binary so that it can add one to it. Each side also keeps a registered Gray-coded copy of that pointer. Only the registered Gray copy crosses to the other domain, through two flip-flops on every bit. Each side compares its own pointer against the synchronized copy from the other side to produce its flow-control flag. FULL belongs to the write domain and EMPTY belongs to the read domain. A synchronized copy can only lag the real pointer. For that reason both flags err on the safe side. The flags are registered and computed from the next pointer value, so each flag rises on the same edge that takes the last slot or the last known word.

Top module: `dual_clock_gray_fifo`

## Requirements
- R1: While either reset is low and right after it is released, EMPTY is 1 and FULL is 0, and both pointers start at location 0.
- R2: Words come out in the order they were written. After a read is accepted on a read-clock edge, the word appears on rd_data at that same edge and stays there until the next accepted read.
- R3: Both pointers advance by one per accepted operation and wrap from location 255 back to location 0. A stream longer than 256 words keeps its order across the wrap.
- R4: The pointer that crosses each domain is the registered Gray code of the binary pointer, gray = bin ^ (bin >> 1). That value changes in at most one bit per clock edge.
- R5: With no reads, FULL stays 0 for the first 255 writes and rises on the write-clock edge that accepts the 256th word.
- R6: A write presented while FULL is 1 is dropped. The write pointer does not move, and the dropped word never appears on the read side.
- R7: A read presented while EMPTY is 1 is dropped. The read pointer does not move, and rd_data keeps its previous value.
- R8: EMPTY rises on the read-clock edge that accepts the last word known to the read side. After a write into an empty FIFO, EMPTY falls no later than the 6th read-clock edge after the write.
- R9: Once a full FIFO has been read, FULL falls no later than the 10th write-clock edge after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset of the write side |
| wr_en | input | 1 | Push request; accepted when FULL is 0 |
| wr_data | input | DATA_W | Word to push |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset of the read side |
| rd_en | input | 1 | Pop request; accepted when EMPTY is 0 |
| rd_data | output | DATA_W | Last word popped, registered |
| full | output | 1 | No free slot as seen by the write side |
| empty | output | 1 | No unread word as seen by the read side |

## Verification
The assertions check the following on every cycle:
- The write pointer never runs more than 256 locations ahead of the synchronized read pointer.
- The read pointer never passes the synchronized write pointer.
- Each registered Gray pointer changes in at most one bit.
- Writes blocked by FULL and reads blocked by EMPTY leave the pointers and rd_data unchanged.
- Each pointer wraps from 255 to 0.

Only the bench scenarios can show the following:
- Data keeps its order across the wrap when the two clocks differ.
- FULL rises at exactly 256 words.
- A dropped word never surfaces on the read side.
- The flags clear within their bounded delays after the other side moves.

// File: rtl/dual_clock_gray_fifo.sv
module dual_clock_gray_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] SPAN = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    for (int i = 0; i < PTR_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // write side
  logic [PTR_W-1:0] wbin, wgray, rg_s1, rg_s2;
  wire              wr_ok   = wr_en && !full;
  wire [PTR_W-1:0]  wbin_nx = wbin + PTR_W'(wr_ok);
  wire [PTR_W-1:0]  rsync   = from_gray(rg_s2);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      full  <= (wbin_nx - rsync) == SPAN;
    end
  end

  always_ff @(posedge wr_clk)
    if (wr_ok) mem[wbin[ADDR_W-1:0]] <= wr_data;

  // read side
  logic [PTR_W-1:0] rbin, rgray, wg_s1, wg_s2;
  wire              rd_ok   = rd_en && !empty;
  wire [PTR_W-1:0]  rbin_nx = rbin + PTR_W'(rd_ok);
  wire [PTR_W-1:0]  wsync   = from_gray(wg_s2);

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      empty   <= 1'b1;
      rd_data <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      empty <= rbin_nx == wsync;
      if (rd_ok) rd_data <= mem[rbin[ADDR_W-1:0]];
    end
  end

  // checks
  assert_no_overflow_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wbin - rsync) <= SPAN);
  assert_no_underflow_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (wsync - rbin) <= SPAN);
  assert_wgray_step_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rgray_step_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  assert_full_blocks_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && full) |=> wbin == $past(wbin));
  assert_empty_blocks_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && empty) |=> (rbin == $past(rbin)) && $stable(rd_data));
  assert_wrap_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ok && wbin[ADDR_W-1:0] == ADDR_W'(DEPTH - 1)) |=> wbin[ADDR_W-1:0] == '0);
endmodule

// File: tb/dual_clock_gray_fifo_test.sv
module dual_clock_gray_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
  localparam int NVEC = 16;
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3,
                                        8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0};

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic full, empty;
  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dual_clock_gray_fifo #(.DATA_W(8), .ADDR_W(8)) uut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .full(full), .empty(empty));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge rd_clk);
    while (empty) @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    d = rd_data;
  endtask

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, held;
    int n;
    repeat (3) @(negedge rd_clk);
    chk("R1 empty in reset", 32'(empty), 1);
    chk("R1 full in reset", 32'(full), 0);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (2) @(negedge rd_clk);
    chk("R1 empty after reset", 32'(empty), 1);
    chk("R1 full after reset", 32'(full), 0);

    // empty deasserts after one write
    push(8'h77);
    n = 0;
    while (empty && n < 20) begin @(negedge rd_clk); n++; end
    chk("R8 empty falls within 6 rd edges", 32'(n <= 6), 1);
    pop(d);
    chk("R2 single word", 32'(d), 32'h77);
    chk("R8 empty after last word", 32'(empty), 1);

    // vector table
    for (int i = 0; i < NVEC; i++) push(VEC[i]);
    for (int i = 0; i < NVEC; i++) begin
      pop(d);
      chk("R2 order", 32'(d), 32'(VEC[i]));
    end

    // fill to full across the wrap
    repeat (10) @(negedge wr_clk);
    for (int i = 0; i < 256; i++) begin
      if (i == 255) chk("R5 full low at 255", 32'(full), 0);
      push(8'(i) ^ 8'h5A);
    end
    chk("R5 full after 256", 32'(full), 1);
    push(8'hEE);
    chk("R6 full still set", 32'(full), 1);

    pop(d);
    chk("R3 R4 first after wrap", 32'(d), 32'h5A);
    n = 0;
    @(negedge wr_clk);
    while (full && n < 20) begin @(negedge wr_clk); n++; end
    chk("R9 full clears", 32'(n <= 10), 1);
    for (int i = 1; i < 256; i++) begin
      pop(d);
      chk("R3 R4 order across wrap", 32'(d), 32'(8'(i) ^ 8'h5A));
    end
    chk("R8 empty after drain", 32'(empty), 1);
    repeat (8) @(negedge rd_clk);
    chk("R6 dropped word absent", 32'(empty), 1);

    // reads while empty
    held = rd_data;
    @(negedge rd_clk);
    rd_en = 1;
    repeat (5) @(negedge rd_clk);
    rd_en = 0;
    chk("R7 rd_data held", 32'(rd_data), 32'(held));
    chk("R7 still empty", 32'(empty), 1);
    push(8'h33);
    pop(d);
    chk("R7 pointer unmoved", 32'(d), 32'h33);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule